// File: doc/BRIEF.md
# SDIO Flow-Control Credit Counters

This block holds the two slave-side running totals that let an SDIO host pace its transfers without any handshake. The first is a receive-buffer token count. The slave application adds to it each time it hands empty receive buffers to the link. The count is published as a 12-bit field inside a 32-bit host-visible register. The second is a transmit byte total. The application adds to it each time it queues outbound data.

Neither total is a current fill level. Both only grow and wrap. The host keeps its own totals of buffers consumed and bytes read, and it finds what is available by modular subtraction. A partly filled buffer at the end of a host write counts as a whole buffer consumed.

The host reads both registers one byte at a time. A read of byte 0 of either register freezes a copy of the whole register. Bytes 1 to 3 are then served from that copy, so an increment that lands between byte reads cannot tear the value. Each queue event also raises a one-cycle new-packet pulse, which can feed one of the host interrupt sources.

Top module: `sdio_credit_counters`

## Requirements
- R1: After reset both totals are zero, `host_rd_data` is 0x00 and `new_pkt` is low.
- R2: When `tok_inc_valid` is high, the token total grows by `tok_inc_cnt` at the clock edge. The total sits in bits 27:16 of the token register at byte address 0x044. Byte address base+k returns register bits 8k+7:8k, so byte 0x046 holds total bits 7:0 and byte 0x047 holds total bits 11:8 in its low nibble.
- R3: Bits 15:0 and 31:28 of the token register always read as zero. Bytes 0x044 and 0x045 therefore return 0x00, and the high nibble of byte 0x047 is 0.
- R4: When `len_add_valid` is high, the byte total grows by `len_add_bytes` at the clock edge. It is read as bytes 0x060 (bits 7:0) to 0x063 (bits 31:24).
- R5: A byte read requested with `host_rd_en` appears on `host_rd_data` one clock later. `host_rd_data` holds its value while `host_rd_en` is low.
- R6: A read of byte offset 0 of either register captures the whole register as a snapshot. Reads of offsets 1 to 3 of that register return snapshot bytes, unaffected by increments made after the capture.
- R7: `new_pkt` is high for exactly the one cycle after each cycle in which `len_add_valid` is high, and low otherwise.
- R8: A read of any address outside 0x044–0x047 and 0x060–0x063 returns 0x00 and leaves both snapshots unchanged.
- R9: The token total wraps modulo 4096 and the byte total wraps modulo 2^32.
- R10: A byte-0 read in the same cycle as an increment returns, and snapshots, the value before that increment. The increment itself is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_inc_valid | input | 1 | Add receive tokens this cycle |
| tok_inc_cnt | input | 4 | Number of buffers loaded |
| len_add_valid | input | 1 | Queue transmit bytes this cycle |
| len_add_bytes | input | 24 | Number of bytes queued |
| host_rd_en | input | 1 | Host byte read request |
| host_rd_addr | input | 17 | Host byte address |
| host_rd_data | output | 8 | Read byte, valid one cycle after request |
| new_pkt | output | 1 | One-cycle pulse per queue event |

## Verification
The hardest case is a torn read. Byte 0 of the byte total must be captured, and then an increment must carry across a byte boundary before bytes 1 to 3 are fetched. Random interleaving alone seldom lines this up. Directed sequences therefore first bring the total close to a carry. They then read byte 0, apply an increment that carries, and read the upper bytes. The same-cycle read-and-increment case and both wrap points get directed sequences as well: several hundred maximum-size adds push the byte total past 2^32. Long random runs then mix increments, register reads and unmapped reads.

// File: rtl/sdio_credit_pkg.sv
package sdio_credit_pkg;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_TOK  = 2'd1,
      RGN_LEN  = 2'd2
   } rgn_e;

   function automatic logic [BYTE_W-1:0] byte_sel(input logic [REG_W-1:0] word,
                                                  input logic [1:0]       idx);
      return word[idx*BYTE_W +: BYTE_W];
   endfunction

endpackage

// File: rtl/sdio_credit_accum.sv
module sdio_credit_accum #(
   parameter int unsigned CNT_W = 12,
   parameter int unsigned INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_valid,
   input  logic [INC_W-1:0] inc_amt,
   output logic [CNT_W-1:0] count
);

   if (INC_W > CNT_W) begin : g_bad_inc
      $error("sdio_credit_accum: INC_W must not exceed CNT_W");
   end
   if (CNT_W == 0) begin : g_bad_cnt
      $error("sdio_credit_accum: CNT_W must be nonzero");
   end

   logic [CNT_W-1:0] inc_ext;
   logic [CNT_W-1:0] count_nxt;

   assign inc_ext = CNT_W'(inc_amt);

   always_comb begin
      count_nxt = count;
      if (inc_valid) begin
         count_nxt = count + inc_ext;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count_nxt;
      end
   end

endmodule

// File: rtl/sdio_credit_pulse.sv
module sdio_credit_pulse #(
   parameter bit REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic pulse
);

   if (REGISTERED) begin : g_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pulse_q <= 1'b0;
         end else begin
            pulse_q <= evt;
         end
      end
      assign pulse = pulse_q;
   end else begin : g_comb
      assign pulse = evt & rst_n;
   end

endmodule

// File: rtl/sdio_credit_rdport.sv
module sdio_credit_rdport
   import sdio_credit_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned TOK_BASE    = 'h44,
   parameter int unsigned LEN_BASE    = 'h60,
   parameter bit          SNAPSHOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [REG_W-1:0]  tok_word,
   input  logic [REG_W-1:0]  len_word,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int unsigned WADDR_W = ADDR_W - 2;
   localparam logic [WADDR_W-1:0] TOK_WA = WADDR_W'(TOK_BASE >> 2);
   localparam logic [WADDR_W-1:0] LEN_WA = WADDR_W'(LEN_BASE >> 2);

   if ((TOK_BASE % 4) != 0 || (LEN_BASE % 4) != 0) begin : g_bad_align
      $error("sdio_credit_rdport: register bases must be word aligned");
   end
   if ((TOK_BASE >> 2) == (LEN_BASE >> 2)) begin : g_bad_overlap
      $error("sdio_credit_rdport: register bases overlap");
   end
   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_aw
      $error("sdio_credit_rdport: ADDR_W out of range");
   end

   rgn_e              rgn;
   logic [1:0]        idx;
   logic              first_byte;
   logic [REG_W-1:0]  tok_src;
   logic [REG_W-1:0]  len_src;
   logic [BYTE_W-1:0] sel_byte;

   assign idx        = rd_addr[1:0];
   assign first_byte = (idx == 2'd0);

   always_comb begin
      if (rd_addr[ADDR_W-1:2] == TOK_WA) begin
         rgn = RGN_TOK;
      end else if (rd_addr[ADDR_W-1:2] == LEN_WA) begin
         rgn = RGN_LEN;
      end else begin
         rgn = RGN_NONE;
      end
   end

   if (SNAPSHOT_EN) begin : g_snap
      logic [REG_W-1:0] tok_snap;
      logic [REG_W-1:0] len_snap;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tok_snap <= '0;
            len_snap <= '0;
         end else if (rd_en && first_byte) begin
            if (rgn == RGN_TOK) begin
               tok_snap <= tok_word;
            end
            if (rgn == RGN_LEN) begin
               len_snap <= len_word;
            end
         end
      end

      assign tok_src = first_byte ? tok_word : tok_snap;
      assign len_src = first_byte ? len_word : len_snap;
   end else begin : g_live
      assign tok_src = tok_word;
      assign len_src = len_word;
   end

   always_comb begin
      unique case (rgn)
         RGN_TOK: sel_byte = byte_sel(tok_src, idx);
         RGN_LEN: sel_byte = byte_sel(len_src, idx);
         default: sel_byte = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= sel_byte;
      end
   end

endmodule

// File: rtl/sdio_credit_counters.sv
module sdio_credit_counters
   import sdio_credit_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned TOK_W       = 12,
   parameter int unsigned TOK_LSB     = 16,
   parameter int unsigned TOK_INC_W   = 4,
   parameter int unsigned LEN_W       = 32,
   parameter int unsigned LEN_INC_W   = 24,
   parameter int unsigned TOK_BASE    = 'h44,
   parameter int unsigned LEN_BASE    = 'h60,
   parameter bit          SNAPSHOT_EN = 1'b1,
   parameter bit          PULSE_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tok_inc_valid,
   input  logic [TOK_INC_W-1:0] tok_inc_cnt,
   input  logic                 len_add_valid,
   input  logic [LEN_INC_W-1:0] len_add_bytes,
   input  logic                 host_rd_en,
   input  logic [ADDR_W-1:0]    host_rd_addr,
   output logic [BYTE_W-1:0]    host_rd_data,
   output logic                 new_pkt
);

   localparam int unsigned TOK_TOP = TOK_LSB + TOK_W;

   if (TOK_TOP > REG_W) begin : g_bad_tok
      $error("sdio_credit_counters: token field exceeds register width");
   end
   if (LEN_W > REG_W) begin : g_bad_len
      $error("sdio_credit_counters: LEN_W exceeds register width");
   end

   logic [TOK_W-1:0] tok_count;
   logic [LEN_W-1:0] len_count;
   logic [REG_W-1:0] tok_word;
   logic [REG_W-1:0] len_word;

   sdio_credit_accum #(
      .CNT_W (TOK_W),
      .INC_W (TOK_INC_W)
   ) u_tok_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_valid (tok_inc_valid),
      .inc_amt   (tok_inc_cnt),
      .count     (tok_count)
   );

   sdio_credit_accum #(
      .CNT_W (LEN_W),
      .INC_W (LEN_INC_W)
   ) u_len_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_valid (len_add_valid),
      .inc_amt   (len_add_bytes),
      .count     (len_count)
   );

   always_comb begin
      tok_word = '0;
      tok_word[TOK_LSB +: TOK_W] = tok_count;
   end

   assign len_word = REG_W'(len_count);

   sdio_credit_rdport #(
      .ADDR_W      (ADDR_W),
      .TOK_BASE    (TOK_BASE),
      .LEN_BASE    (LEN_BASE),
      .SNAPSHOT_EN (SNAPSHOT_EN)
   ) u_rdport (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (host_rd_en),
      .rd_addr  (host_rd_addr),
      .tok_word (tok_word),
      .len_word (len_word),
      .rd_data  (host_rd_data)
   );

   sdio_credit_pulse #(
      .REGISTERED (PULSE_REG)
   ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (len_add_valid),
      .pulse (new_pkt)
   );

endmodule

// File: rtl/sdio_credit_counters_chk.sv
module sdio_credit_counters_chk #(
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned TOK_W     = 12,
   parameter int unsigned TOK_LSB   = 16,
   parameter int unsigned TOK_INC_W = 4,
   parameter int unsigned LEN_W     = 32,
   parameter int unsigned LEN_INC_W = 24,
   parameter int unsigned TOK_BASE  = 'h44,
   parameter int unsigned LEN_BASE  = 'h60,
   parameter bit          PULSE_REG = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tok_inc_valid,
   input logic [TOK_INC_W-1:0] tok_inc_cnt,
   input logic                 len_add_valid,
   input logic [LEN_INC_W-1:0] len_add_bytes,
   input logic                 host_rd_en,
   input logic [ADDR_W-1:0]    host_rd_addr,
   input logic [7:0]           host_rd_data,
   input logic                 new_pkt,
   input logic [TOK_W-1:0]     tok_count,
   input logic [LEN_W-1:0]     len_count
);

   localparam logic [ADDR_W-1:0] TA = ADDR_W'(TOK_BASE);
   localparam logic [ADDR_W-1:0] LA = ADDR_W'(LEN_BASE);

   logic unmapped;
   assign unmapped = (host_rd_addr[ADDR_W-1:2] != TA[ADDR_W-1:2]) &&
                     (host_rd_addr[ADDR_W-1:2] != LA[ADDR_W-1:2]);

   AST_TOK_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
      tok_inc_valid |=> tok_count == TOK_W'($past(tok_count) + TOK_W'($past(tok_inc_cnt)))); // R2

   AST_TOK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_inc_valid |=> $stable(tok_count)); // R2

   AST_LEN_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
      len_add_valid |=> len_count == LEN_W'($past(len_count) + LEN_W'($past(len_add_bytes)))); // R4

   AST_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !len_add_valid |=> $stable(len_count)); // R4

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd_en |=> $stable(host_rd_data)); // R5

   AST_TOK_PAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_en && (host_rd_addr == TA || host_rd_addr == TA + 1'b1) |=> host_rd_data == 8'h00); // R3

   if (TOK_LSB + TOK_W > 24 && TOK_LSB + TOK_W < 32) begin : g_pad_hi
      localparam int unsigned HI_USED = TOK_LSB + TOK_W - 24;
      AST_TOK_PAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
         host_rd_en && host_rd_addr == TA + ADDR_W'(3) |=> (host_rd_data >> HI_USED) == 8'h00); // R3
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_en && unmapped |=> host_rd_data == 8'h00); // R8

   AST_LIVE_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_en && host_rd_addr == LA |=> host_rd_data == $past(len_count[7:0])); // R10

   if (PULSE_REG) begin : g_pulse_chk
      AST_PULSE_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
         len_add_valid |=> new_pkt); // R7
      AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
         !len_add_valid |=> !new_pkt); // R7
   end

endmodule

bind sdio_credit_counters sdio_credit_counters_chk #(
   .ADDR_W    (ADDR_W),
   .TOK_W     (TOK_W),
   .TOK_LSB   (TOK_LSB),
   .TOK_INC_W (TOK_INC_W),
   .LEN_W     (LEN_W),
   .LEN_INC_W (LEN_INC_W),
   .TOK_BASE  (TOK_BASE),
   .LEN_BASE  (LEN_BASE),
   .PULSE_REG (PULSE_REG)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tok_inc_valid (tok_inc_valid),
   .tok_inc_cnt   (tok_inc_cnt),
   .len_add_valid (len_add_valid),
   .len_add_bytes (len_add_bytes),
   .host_rd_en    (host_rd_en),
   .host_rd_addr  (host_rd_addr),
   .host_rd_data  (host_rd_data),
   .new_pkt       (new_pkt),
   .tok_count     (tok_count),
   .len_count     (len_count)
);

// File: tb/sdio_credit_counters_tb.sv
`timescale 1ns/1ps
module sdio_credit_counters_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tok_inc_valid = 1'b0;
   logic [3:0]  tok_inc_cnt = '0;
   logic        len_add_valid = 1'b0;
   logic [23:0] len_add_bytes = '0;
   logic        host_rd_en = 1'b0;
   logic [16:0] host_rd_addr = '0;
   logic [7:0]  host_rd_data;
   logic        new_pkt;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // bench model
   logic [11:0] m_tok  = '0;
   logic [31:0] m_len  = '0;
   logic [31:0] m_stok = '0;
   logic [31:0] m_slen = '0;
   logic [7:0]  m_rd   = '0;

   always #4 clk = ~clk;

   sdio_credit_counters u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tok_inc_valid (tok_inc_valid),
      .tok_inc_cnt   (tok_inc_cnt),
      .len_add_valid (len_add_valid),
      .len_add_bytes (len_add_bytes),
      .host_rd_en    (host_rd_en),
      .host_rd_addr  (host_rd_addr),
      .host_rd_data  (host_rd_data),
      .new_pkt       (new_pkt)
   );

   function automatic logic [31:0] tok_word(input logic [11:0] t);
      return {4'h0, t, 16'h0000};
   endfunction

   function automatic logic [7:0] exp_byte(input logic [16:0] a);
      logic [31:0] w;
      if (a[16:2] == 15'(17'h044 >> 2)) begin
         w = (a[1:0] == 2'd0) ? tok_word(m_tok) : m_stok;
      end else if (a[16:2] == 15'(17'h060 >> 2)) begin
         w = (a[1:0] == 2'd0) ? m_len : m_slen;
      end else begin
         return 8'h00;
      end
      return w[a[1:0]*8 +: 8];
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one clock of stimulus, checks after the edge, then model update
   task automatic step(input bit tv, input logic [3:0] tc, input bit lv, input logic [23:0] lb,
                       input bit re, input logic [16:0] a, input string tag, input bit chk);
      logic [7:0] e;
      @(negedge clk);
      tok_inc_valid = tv; tok_inc_cnt = tc;
      len_add_valid = lv; len_add_bytes = lb;
      host_rd_en = re;    host_rd_addr = a;
      e = re ? exp_byte(a) : m_rd;
      @(posedge clk);
      #1;
      m_rd = e;
      if (chk) begin
         check(tag, 32'(host_rd_data), 32'(e));
         check("R7", 32'(new_pkt), 32'(lv));
      end
      if (re && a[1:0] == 2'd0) begin
         if (a[16:2] == 15'(17'h044 >> 2)) m_stok = tok_word(m_tok);
         if (a[16:2] == 15'(17'h060 >> 2)) m_slen = m_len;
      end
      if (tv) m_tok = m_tok + 12'(tc);
      if (lv) m_len = m_len + 32'(lb);
   endtask

   task automatic rd(input logic [16:0] a, input string tag);
      step(1'b0, 4'h0, 1'b0, 24'h0, 1'b1, a, tag, 1'b1);
   endtask

   task automatic rd_reg(input logic [16:0] base, input string tag);
      for (int k = 0; k < 4; k++) rd(base + 17'(k), tag);
   endtask

   task automatic add_tok(input logic [3:0] n);
      step(1'b1, n, 1'b0, 24'h0, 1'b0, 17'h0, "R2", 1'b1);
   endtask

   task automatic add_len(input logic [23:0] n);
      step(1'b0, 4'h0, 1'b1, n, 1'b0, 17'h0, "R4", 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      check("R1", 32'(host_rd_data), 32'h0);
      check("R1", 32'(new_pkt), 32'h0);
      rd_reg(17'h044, "R1");
      rd_reg(17'h060, "R1");

      // R2 / R3 token accumulation and padding
      add_tok(4'd5);
      add_tok(4'd7);
      add_tok(4'd15);
      rd_reg(17'h044, "R2");
      check("R2", 32'(host_rd_data), 32'(m_tok[11:8]));
      rd(17'h044, "R3");
      check("R3", 32'(host_rd_data), 32'h0);
      rd(17'h045, "R3");
      check("R3", 32'(host_rd_data), 32'h0);

      // R4 byte total
      add_len(24'h0000FF);
      add_len(24'h123456);
      rd_reg(17'h060, "R4");

      // R5 hold while idle
      for (int k = 0; k < 3; k++) step(1'b1, 4'd1, 1'b1, 24'h10, 1'b0, 17'h060, "R5", 1'b1);

      // R6 torn-read protection: capture, carry across bytes, then upper bytes
      add_len(24'(32'h100 - {24'h0, m_len[7:0]} - 32'h1));
      rd(17'h060, "R6");
      add_len(24'h00FFFF);
      add_len(24'h000002);
      rd(17'h061, "R6");
      check("R6", 32'(host_rd_data), 32'(m_slen[15:8]));
      rd(17'h062, "R6");
      rd(17'h063, "R6");
      rd(17'h044, "R6");
      add_tok(4'd15);
      rd(17'h046, "R6");
      rd(17'h047, "R6");

      // R10 same-cycle increment and byte-0 read
      step(1'b0, 4'h0, 1'b1, 24'h0000F3, 1'b1, 17'h060, "R10", 1'b1);
      rd(17'h061, "R10");
      rd(17'h060, "R10");
      step(1'b1, 4'd9, 1'b0, 24'h0, 1'b1, 17'h044, "R10", 1'b1);
      rd(17'h046, "R10");

      // R8 unmapped addresses, snapshots untouched
      add_len(24'hABCDEF);
      rd(17'h050, "R8");
      rd(17'h1F000, "R8");
      rd(17'h064, "R8");
      rd(17'h043, "R8");
      rd(17'h061, "R8");
      rd(17'h062, "R8");

      // R9 wrap of both totals
      for (int k = 0; k < 280; k++) add_tok(4'd15);
      rd_reg(17'h044, "R9");
      for (int k = 0; k < 260; k++) add_len(24'hFFFFFF);
      rd_reg(17'h060, "R9");

      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic [16:0] a;
         int sel;
         sel = int'($urandom_range(0, 9));
         if (sel < 4)      a = 17'h044 + 17'($urandom_range(0, 3));
         else if (sel < 8) a = 17'h060 + 17'($urandom_range(0, 3));
         else              a = 17'($urandom);
         step(($urandom_range(0, 2) == 0), 4'($urandom), ($urandom_range(0, 3) == 0),
              24'($urandom), ($urandom_range(0, 1) == 1), a, "R6", 1'b1);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule